// File: doc/BRIEF.md
# Inverting Bidirectional Latched Bus Transceiver

This block joins two 8-bit buses, called A and B, through two independent storage banks, one for each direction of travel. The forward bank takes its data from A and presents it on B. The reverse bank takes its data from B and presents it on A. Every value that crosses the block comes out bitwise inverted.

Each direction has three active-low controls: an enable, an open control and a drive control. The enable gates the other two. While the enable and the open control are both low, the bank is transparent: its output follows the inverse of its source in the same cycle, and its storage loads the source on every rising clock edge. When the open control goes high, the bank keeps the value it loaded at the last edge on which it was open. The drive control, qualified by the enable, sets a separate output-enable flag. The data vector itself always carries the inverted bank view. Neither bus is a real tri-state pad: each side is split into an input vector, an output vector and an output-enable bit, so a pad ring or bus fabric around the block does the actual driving.

Storage is built from clock-enabled registers with a combinational bypass, which gives latch behaviour to inputs that are synchronous to `clk`. The active-low reset is asynchronous on assertion and released synchronously inside the block, and it clears both banks.

Top module: `xcvr_inv_latch`

## Requirements
- R1: While reset is held, and after it is released, both banks hold all zeros. With all controls high, `a_dout` and `b_dout` therefore read 8'hFF, and `a_dout_oe` and `b_dout_oe` read 0.
- R2: While a direction's enable and open control are both low, its output vector equals the bitwise inverse of its source vector in the same cycle (forward: `b_dout == ~a_din`; reverse: `a_dout == ~b_din`).
- R3: When the open control goes high, the output vector shows the inverse of the source value present at the last rising edge on which enable and open were both low. It stays there while the source changes.
- R4: While a direction's enable is high, its storage does not load, even if its open control is low. After the enable returns low with open high, the output still shows the value stored before the freeze.
- R5: A direction's output-enable flag is 1 exactly when its enable and its drive control are both low. This holds for all eight combinations of the three controls.
- R6: The two directions are independent. Both banks can hold different values at the same time, and both output-enable flags can be 1 together.
- R7: The output data vector does not depend on the output-enable. It shows the inverted transparent or stored value even when the output-enable flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage loads on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| a_din | input | 8 | A-bus input, source of the forward bank |
| a_dout | output | 8 | A-bus output data, inverted reverse-bank view |
| a_dout_oe | output | 1 | A-bus output-enable, active high |
| b_din | input | 8 | B-bus input, source of the reverse bank |
| b_dout | output | 8 | B-bus output data, inverted forward-bank view |
| b_dout_oe | output | 1 | B-bus output-enable, active high |
| fwd_en_n | input | 1 | Forward enable, active low |
| fwd_open_n | input | 1 | Forward open (transparent) control, active low |
| fwd_drive_n | input | 1 | Forward drive control, active low |
| rev_en_n | input | 1 | Reverse enable, active low |
| rev_open_n | input | 1 | Reverse open (transparent) control, active low |
| rev_drive_n | input | 1 | Reverse drive control, active low |

## Verification
The bench builds the block with its default width of 8 bits. At that width every one of the 256 forward values can be stored and read back, each paired with a different, arithmetically derived reverse value. This covers every data bit of both directions in both polarities. The small control space is also swept in full: all eight enable/open/drive combinations for each direction, each checked against a preloaded stored value and a different live source. This shows the gating of transparency and drive, and the freeze when the enable is high.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int NUM_DIRS = 2;
  localparam int DIR_FWD  = 0;
  localparam int DIR_REV  = 1;

  typedef struct packed {
    logic en_n;
    logic open_n;
    logic drive_n;
  } dir_ctrl_t;

endpackage

// File: rtl/xcvr_ctrl_decode.sv
module xcvr_ctrl_decode
  import xcvr_pkg::*;
(
  input  dir_ctrl_t ctrl,
  output logic      open_o,
  output logic      drive_o
);

  logic enabled;

  always_comb begin
    enabled = ~ctrl.en_n;
    open_o  = enabled & ~ctrl.open_n;
    drive_o = enabled & ~ctrl.drive_n;
  end

endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst,
  output logic             dst_oe
);

  logic             open_w;
  logic             drive_w;
  logic             store_en;
  logic [WIDTH-1:0] store_d;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] view;
  logic             live_q;

  xcvr_ctrl_decode u_dec (
    .ctrl    (ctrl),
    .open_o  (open_w),
    .drive_o (drive_w)
  );

  // next-state
  always_comb begin
    store_en = open_w;
    store_d  = src;
  end

  // storage register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (store_en) begin
      store_q <= store_d;
    end
  end

  // one cycle past reset: gates history-based checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  // per-bit bypass mux and inverting output stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign view[i] = open_w ? src[i] : store_q[i];
    assign dst[i]  = ~view[i];
  end

  assign dst_oe = drive_w;

  // R2: transparent bank shows inverted source
  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en_n && !ctrl.open_n) |-> (dst == ~src));

  // R3: closing captures the source of the last open edge
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(!ctrl.en_n && !ctrl.open_n) && !(!ctrl.en_n && !ctrl.open_n))
      |-> (dst == ~$past(src)));

  // R4: enable high freezes the output value
  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && ctrl.en_n && $past(ctrl.en_n)) |-> $stable(dst));

  // R5: enable high never drives
  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.en_n |-> !dst_oe);

endmodule

// File: rtl/xcvr_inv_latch.sv
module xcvr_inv_latch
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_dout_oe,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_dout_oe,
  input  logic             fwd_en_n,
  input  logic             fwd_open_n,
  input  logic             fwd_drive_n,
  input  logic             rev_en_n,
  input  logic             rev_open_n,
  input  logic             rev_drive_n
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  dir_ctrl_t        ctrl_arr [NUM_DIRS];
  logic [WIDTH-1:0] src_arr  [NUM_DIRS];
  logic [WIDTH-1:0] dst_arr  [NUM_DIRS];
  logic             oe_arr   [NUM_DIRS];

  always_comb begin
    ctrl_arr[DIR_FWD] = '{en_n: fwd_en_n, open_n: fwd_open_n, drive_n: fwd_drive_n};
    ctrl_arr[DIR_REV] = '{en_n: rev_en_n, open_n: rev_open_n, drive_n: rev_drive_n};
    src_arr[DIR_FWD]  = a_din;
    src_arr[DIR_REV]  = b_din;
  end

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_latch_bank #(
      .WIDTH (WIDTH)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .ctrl   (ctrl_arr[d]),
      .src    (src_arr[d]),
      .dst    (dst_arr[d]),
      .dst_oe (oe_arr[d])
    );
  end

  assign b_dout    = dst_arr[DIR_FWD];
  assign b_dout_oe = oe_arr[DIR_FWD];
  assign a_dout    = dst_arr[DIR_REV];
  assign a_dout_oe = oe_arr[DIR_REV];

  // R1: banks read cleared while reset is active
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_int_n && fwd_en_n && rev_en_n) |-> (a_dout == '1 && b_dout == '1 && !a_dout_oe && !b_dout_oe));

endmodule

// File: tb/xcvr_inv_latch_test.sv
module xcvr_inv_latch_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_din, b_din, a_dout, b_dout;
  logic         a_dout_oe, b_dout_oe;
  logic         fwd_en_n, fwd_open_n, fwd_drive_n;
  logic         rev_en_n, rev_open_n, rev_drive_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_inv_latch #(.WIDTH(W)) uut (
    .clk (clk), .rst_n (rst_n),
    .a_din (a_din), .a_dout (a_dout), .a_dout_oe (a_dout_oe),
    .b_din (b_din), .b_dout (b_dout), .b_dout_oe (b_dout_oe),
    .fwd_en_n (fwd_en_n), .fwd_open_n (fwd_open_n), .fwd_drive_n (fwd_drive_n),
    .rev_en_n (rev_en_n), .rev_open_n (rev_open_n), .rev_drive_n (rev_drive_n)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // open both banks on fv / rv, then close them and change sources
  task automatic load_both(input logic [W-1:0] fv, input logic [W-1:0] rv);
    @(negedge clk);
    fwd_en_n = 1'b0; fwd_open_n = 1'b0;
    rev_en_n = 1'b0; rev_open_n = 1'b0;
    a_din = fv; b_din = rv;
    #1;
    chk("R2 fwd transparent", b_dout, ~fv);
    chk("R2 rev transparent", a_dout, ~rv);
    @(negedge clk);
    fwd_open_n = 1'b1; rev_open_n = 1'b1;
    a_din = ~fv; b_din = ~rv;
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    a_din = '0; b_din = '0;
    fwd_en_n = 1'b1; fwd_open_n = 1'b1; fwd_drive_n = 1'b1;
    rev_en_n = 1'b1; rev_open_n = 1'b1; rev_drive_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 a_dout", a_dout, 8'hFF);
    chk("R1 b_dout", b_dout, 8'hFF);
    chk("R1 a_dout_oe", {7'd0, a_dout_oe}, 8'h00);
    chk("R1 b_dout_oe", {7'd0, b_dout_oe}, 8'h00);

    // R3 / R6 full data sweep, both directions at once, both driving
    fwd_drive_n = 1'b0; rev_drive_n = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] fv, rv;
      fv = W'(v);
      rv = W'(v * 37 + 11);
      load_both(fv, rv);
      chk("R3 fwd hold", b_dout, ~fv);
      chk("R6 rev hold", a_dout, ~rv);
      if (v % 64 == 0) begin
        chk("R6 both oe", {6'd0, a_dout_oe, b_dout_oe}, 8'h03);
      end
    end

    // R4 freeze with enable high while open pulses low
    load_both(8'h5A, 8'hC3);
    @(negedge clk);
    fwd_en_n = 1'b1; fwd_open_n = 1'b0; a_din = 8'hFF;
    rev_en_n = 1'b1; rev_open_n = 1'b0; b_din = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk("R4 fwd frozen", b_dout, ~8'h5A);
    chk("R4 rev frozen", a_dout, ~8'hC3);
    @(negedge clk);
    fwd_open_n = 1'b1; rev_open_n = 1'b1;
    @(negedge clk);
    fwd_en_n = 1'b0; rev_en_n = 1'b0;
    #1;
    chk("R4 fwd unchanged after freeze", b_dout, ~8'h5A);
    chk("R4 rev unchanged after freeze", a_dout, ~8'hC3);

    // R5 / R7 control sweep per direction
    for (int c = 0; c < 8; c++) begin
      logic e, o, d;
      e = c[2]; o = c[1]; d = c[0];
      load_both(8'h3C, 8'h96);
      @(negedge clk);
      fwd_en_n = e; fwd_open_n = o; fwd_drive_n = d; a_din = 8'hA5;
      #1;
      chk("R5 fwd oe", {7'd0, b_dout_oe}, {7'd0, (!e && !d)});
      chk("R7 fwd data", b_dout, (!e && !o) ? ~8'hA5 : ~8'h3C);
      chk("R6 rev untouched", a_dout, ~8'h96);
      @(negedge clk);
      fwd_en_n = 1'b0; fwd_open_n = 1'b1; fwd_drive_n = 1'b1;
    end
    for (int c = 0; c < 8; c++) begin
      logic e, o, d;
      e = c[2]; o = c[1]; d = c[0];
      load_both(8'h81, 8'h7E);
      @(negedge clk);
      rev_en_n = e; rev_open_n = o; rev_drive_n = d; b_din = 8'h24;
      #1;
      chk("R5 rev oe", {7'd0, a_dout_oe}, {7'd0, (!e && !d)});
      chk("R7 rev data", a_dout, (!e && !o) ? ~8'h24 : ~8'h7E);
      chk("R6 fwd untouched", b_dout, ~8'h81);
      @(negedge clk);
      rev_en_n = 1'b0; rev_open_n = 1'b1; rev_drive_n = 1'b1;
    end

    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule